// File: doc/BRIEF.md
# Triplicated Brown-Out Reset Manager

This block turns three redundant supply-undervoltage comparator flags into one system reset request for the chip's reset controller. Each flag is brought into the clock domain through its own two-flop synchronizer. The three synchronized flags are then put to a two-of-three vote, so that a single upset or a single faulty detector can neither raise nor drop the reset. While the voted decision reports undervoltage, the reset request is held high. After the supply recovers, a hold timer keeps the request high for a fixed number of further cycles. Any fresh undervoltage inside that window reloads the timer.

The block also passes a registered 3-bit trip-threshold code to the analog comparators. A registered bypass setting lets the chip run with the detectors ignored. Bypass only becomes effective after the reset request has deasserted once, so a chip can never power up with an unchecked supply. A mismatch output reports whenever the three synchronized flags disagree, which makes differences between the trip points of the three detectors visible.

All pins are plain level signals: there is no data stream and no handshake.

Top module: `bor_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_req` is 1, `trip_adj` is 0 and `flag_mismatch` is 0. After `rst_n` rises with all flags at 1, `rst_req` stays 1 for as long as the vote reports undervoltage.
- R2: A flag (1 = supply below threshold) reaches the vote through two flip-flops. After all three pins go from 0 to 1 at a released, unbypassed block, `rst_req` is still 0 after the first rising edge and is 1 after the second.
- R3: The undervoltage decision is the majority of the three synchronized flags. Any pattern with one flag set leaves `rst_req` at 0. Any pattern with two or three flags set drives it to 1.
- R4: After the flag pins drop so that the vote clears, `rst_req` stays 1 through the HOLD+1 rising edges that follow the pin change and is 0 after edge HOLD+2. HOLD defaults to 1024.
- R5: A new voted undervoltage while the hold window runs reloads it, so the HOLD cycles count from the last clear.
- R6: Once released, a voted undervoltage in operation asserts `rst_req` again.
- R7: `cfg_bypass` (1 = ignore detectors) has no effect until `rst_req` has been 0 once since `rst_n` rose. After that point, while it is 1, undervoltage flags leave `rst_req` at 0.
- R8: `trip_adj` equals the `cfg_trip_code` sampled at the previous rising edge.
- R9: `flag_mismatch` is 1 when the synchronized flags are not all equal. It follows a pin change after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag | input | 3 | Raw comparator flags, 1 = supply below trip point |
| cfg_bypass | input | 1 | 1 = suppress detector reset requests (after first release) |
| cfg_trip_code | input | 3 | Trip-threshold setting from configuration |
| rst_req | output | 1 | Reset request to the chip reset controller, active high |
| trip_adj | output | 3 | Registered threshold adjust code to the comparators |
| flag_mismatch | output | 1 | 1 = synchronized flags disagree |

## Verification
The hardest state to reach is a reload of the hold timer part-way through its window. This needs a clear, a wait of hundreds of cycles, and then a second majority event, after which the release edge is counted exactly against HOLD. The bench drives that sequence directly. The second hard case is the bypass gate: it must be shown to be ignored before the first release and honoured afterwards. The bench holds bypass high from power-up with the flags set, and only later lets the supply recover.

// File: rtl/bor_pkg.sv
package bor_pkg;
  localparam int N_DET  = 3;
  localparam int TRIP_W = 3;

  function automatic logic majority(input logic [N_DET-1:0] f);
    int ones;
    ones = 0;
    for (int i = 0; i < N_DET; i++) ones += int'(f[i]);
    return (ones * 2 > N_DET);
  endfunction
endpackage

// File: rtl/bor_sync2.sv
module bor_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end

  // R2: second stage follows the first one edge later
  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    q == $past(s1));
endmodule

// File: rtl/bor_vote.sv
module bor_vote
  import bor_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DET-1:0] flags,
  output logic             uv,
  output logic             mismatch
);
  logic disagree;

  always_comb begin
    uv       = majority(flags);
    disagree = !((&flags) || !(|flags));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mismatch <= 1'b0;
    else        mismatch <= disagree;
  end

  // R9: mismatch reports the disagreement seen one edge earlier
  a_r9_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch == $past(disagree));
  // R3: a vote never contradicts a unanimous set of flags
  a_r3_unanimous: assert property (@(posedge clk) disable iff (!rst_n)
    ((&flags) |-> uv) and (!(|flags) |-> !uv));
endmodule

// File: rtl/bor_hold.sv
module bor_hold #(
  parameter int HOLD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CW'(HOLD);
    else if (trig)       cnt <= CW'(HOLD);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = trig || (cnt != '0);

  // R5: any trigger reloads the full window
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt == CW'(HOLD)));
  // R4: without a trigger the window counts down by one per cycle
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && cnt != '0) |=> (cnt == CW'($past(cnt) - 1'b1)));
endmodule

// File: rtl/bor_reset_ctrl.sv
module bor_reset_ctrl
  import bor_pkg::*;
#(
  parameter int             HOLD     = 1024,
  parameter logic [TRIP_W-1:0] TRIP_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DET-1:0]  uv_flag,
  input  logic              cfg_bypass,
  input  logic [TRIP_W-1:0] cfg_trip_code,
  output logic              rst_req,
  output logic [TRIP_W-1:0] trip_adj,
  output logic              flag_mismatch
);
  logic [N_DET-1:0] flag_s;
  logic             vote_uv;
  logic             byp_q;
  logic             released_q;
  logic             live_q;
  logic             uv_eff;

  for (genvar i = 0; i < N_DET; i++) begin : g_sync
    bor_sync2 #(.RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(uv_flag[i]), .q(flag_s[i])
    );
  end

  bor_vote u_vote (
    .clk(clk), .rst_n(rst_n), .flags(flag_s),
    .uv(vote_uv), .mismatch(flag_mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q      <= 1'b0;
      trip_adj   <= TRIP_RST;
      released_q <= 1'b0;
      live_q     <= 1'b0;
    end else begin
      byp_q    <= cfg_bypass;
      trip_adj <= cfg_trip_code;
      live_q   <= 1'b1;
      if (!rst_req) released_q <= 1'b1;
    end
  end

  assign uv_eff = vote_uv && !(byp_q && released_q);

  bor_hold #(.HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .trig(uv_eff), .active(rst_req)
  );

  // R8: adjust code is the configuration seen one edge earlier
  a_r8_trip_follow: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (trip_adj == $past(cfg_trip_code)));
  // R6: all flags held high for two edges forces reset when not bypassed
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uv_flag) == '1 && $past(uv_flag, 2) == '1 && !byp_q) |-> rst_req);
  // R7: an active bypass after release keeps a quiet reset quiet
  a_r7_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (released_q && byp_q && $past(released_q && byp_q) && !$past(rst_req))
      |-> !rst_req);
  // R1: before the first release the bypass cannot drop a reset
  a_r1_no_early_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!released_q && vote_uv) |-> rst_req);
endmodule

// File: tb/sim_bor_reset_ctrl.sv
`timescale 1ns/1ps
module sim_bor_reset_ctrl;
  localparam int HOLD = 1024;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] uv_flag;
  logic       cfg_bypass;
  logic [2:0] cfg_trip_code;
  logic       rst_req;
  logic [2:0] trip_adj;
  logic       flag_mismatch;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bor_reset_ctrl #(.HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .cfg_bypass(cfg_bypass),
    .cfg_trip_code(cfg_trip_code), .rst_req(rst_req), .trip_adj(trip_adj),
    .flag_mismatch(flag_mismatch)
  );

  // pattern, expected reset, expected mismatch
  localparam logic [4:0] VEC [8] = '{
    {3'b000, 1'b0, 1'b0}, {3'b001, 1'b0, 1'b1},
    {3'b010, 1'b0, 1'b1}, {3'b100, 1'b0, 1'b1},
    {3'b011, 1'b1, 1'b1}, {3'b101, 1'b1, 1'b1},
    {3'b110, 1'b1, 1'b1}, {3'b111, 1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uv_flag = 3'b111; cfg_bypass = 1'b1; cfg_trip_code = 3'd5;
    repeat (5) @(negedge clk);
    chk("R1 rst_req in reset", {2'b0, rst_req}, 3'd1);
    chk("R1 trip_adj in reset", trip_adj, 3'd0);
    chk("R1 mismatch in reset", {2'b0, flag_mismatch}, 3'd0);
    rst_n = 1'b1;
    step(1);
    chk("R8 trip code 5", trip_adj, 3'd5);
    step(2000);
    chk("R7 bypass ignored before release", {2'b0, rst_req}, 3'd1);
    cfg_bypass = 1'b0;
    step(2);
    uv_flag = 3'b000;
    step(HOLD + 1);
    chk("R4 still held at HOLD+1", {2'b0, rst_req}, 3'd1);
    step(1);
    chk("R4 released at HOLD+2", {2'b0, rst_req}, 3'd0);

    // R2 latency
    uv_flag = 3'b111;
    step(1);
    chk("R2 one edge", {2'b0, rst_req}, 3'd0);
    step(1);
    chk("R2 two edges", {2'b0, rst_req}, 3'd1);
    uv_flag = 3'b000;
    step(HOLD + 3);
    chk("R6 recovered", {2'b0, rst_req}, 3'd0);

    // R9 latency
    uv_flag = 3'b001;
    step(2);
    chk("R9 two edges", {2'b0, flag_mismatch}, 3'd0);
    step(1);
    chk("R9 three edges", {2'b0, flag_mismatch}, 3'd1);
    uv_flag = 3'b000;
    step(4);

    // vector table: R3 majority, R6 re-assert, R9 mismatch
    for (int k = 0; k < 8; k++) begin
      uv_flag = VEC[k][4:2];
      step(3);
      chk("R3 R6 vote", {2'b0, rst_req}, {2'b0, VEC[k][1]});
      chk("R9 mismatch", {2'b0, flag_mismatch}, {2'b0, VEC[k][0]});
      uv_flag = 3'b000;
      step(HOLD + 3);
      chk("R4 recovered", {2'b0, rst_req}, 3'd0);
    end

    // R5 reload mid-window
    uv_flag = 3'b110;
    step(3);
    uv_flag = 3'b000;
    step(500);
    chk("R5 mid window", {2'b0, rst_req}, 3'd1);
    uv_flag = 3'b011;
    step(3);
    uv_flag = 3'b000;
    step(HOLD + 1);
    chk("R5 held after reload", {2'b0, rst_req}, 3'd1);
    step(1);
    chk("R5 released after reload", {2'b0, rst_req}, 3'd0);

    // R7 bypass after release
    cfg_bypass = 1'b1;
    step(2);
    uv_flag = 3'b111;
    step(5);
    chk("R7 bypass suppresses", {2'b0, rst_req}, 3'd0);
    step(1100);
    chk("R7 bypass long", {2'b0, rst_req}, 3'd0);
    uv_flag = 3'b000;
    step(3);
    cfg_bypass = 1'b0;
    step(3);
    chk("R7 bypass off quiet", {2'b0, rst_req}, 3'd0);

    // R8 code change
    cfg_trip_code = 3'd3;
    step(1);
    chk("R8 trip code 3", trip_adj, 3'd3);
    cfg_trip_code = 3'd7;
    step(1);
    chk("R8 trip code 7", trip_adj, 3'd7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule